// File: doc/BRIEF.md
# Video memory DMA sequencer

This block steps a display controller's direct memory transfers, one unit per access slot. It holds the 24-bit source pointer, the 16-bit remaining length, the destination pointer, the step added to the destination and the command code. After each unit it moves, it updates all of them. Three kinds of transfer exist. The first pulls words from the host bus into a small write queue, where each entry carries a due-cycle stamp. The second repeats the value of one seeded queue write over a range of video memory. The third copies bytes inside video memory through a one-byte holding latch.

The surrounding chip supplies the slot timing. `src_slot` marks a slot in which a host-bus fetch may run. `ext_slot` marks an external access slot, in which the queue drains and fill and copy traffic runs. `after_refresh` flags a slot that directly follows a refresh slot. Host-bus data and video memory read data come back in the same cycle as their addresses. A free-running cycle counter decides when each queue entry is due.

The controller has five states. `ST_IDLE` moves on a `start` to `ST_EXT`, `ST_FILL` or `ST_CP_RD`, chosen by the mode bits. `ST_EXT` and `ST_FILL` return to `ST_IDLE` on their last unit. `ST_CP_RD` goes to `ST_CP_WR` after a read. `ST_CP_WR` goes back to `ST_CP_RD` after a write, or to `ST_IDLE` after the last write.

Top module: `vram_dma_seq`

## Requirements
- R1: A `start` is taken only in `ST_IDLE` and loads every register. The mode comes from bits 7:6 of `start_src_hi`: 0x selects a host-bus transfer, 10 selects fill and 11 selects copy. After reset the block is idle, the queue is empty and every register output reads zero.
- R2: After each unit, source bits 7:0 increase by one. Source bits 15:8 increase by one only when bits 7:0 wrap from 0xFF to 0x00. Source bits 23:16 never change.
- R3: After each unit, the destination grows by the 8-bit step value.
- R4: After each unit, the length drops by one. When the new length is zero, `run` falls and `cmd` keeps only its low four bits. A length of 1 therefore ends after exactly one unit.
- R5: A copy takes two eligible `ext_slot` cycles per unit. In the first, `vram_raddr` is the 16-bit source with bit 0 inverted and the returned byte is latched. In the next, a byte write (`mem_byte`=1) puts the latched byte in `mem_wdata[7:0]` at the destination with bit 0 inverted, and only then do the registers advance. A slot in which the queue drains is not eligible.
- R6: A fill `start` queues a seed entry holding `start_fill_data` at `start_dest` and does not advance the registers. In every `ext_slot` while filling with an empty queue, the most recently written queue slot is reused at the current destination, due at once and marked fill. It drains in that same slot with `mem_fill`=1 and the seed data, the registers advance, and the queue reads empty afterwards.
- R7: In a host-bus transfer, `ext_addr` shows the 24-bit source. Each accepted `src_slot` queues {destination, `ext_rdata`} due at the current cycle plus LATENCY×16 when `wide_mode`=1 or LATENCY×20 when it is 0 (32 or 40 at the default), then advances.
- R8: No host-bus entry is queued in a slot with `after_refresh`=1 or while the queue holds QDEPTH (4) entries.
- R9: In an `ext_slot` whose oldest entry has reached its due cycle, that entry drains: one `mem_we` cycle with its address and data. Entries drain in order, and a queue push and a drain can happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load registers and begin a transfer |
| start_src_hi | input | 8 | Source bits 23:16; bits 7:6 select the mode |
| start_src_mid | input | 8 | Source bits 15:8 |
| start_src_lo | input | 8 | Source bits 7:0 |
| start_len | input | 16 | Unit count |
| start_inc | input | 8 | Destination step per unit |
| start_dest | input | 16 | Destination address |
| start_cmd | input | 6 | Command code |
| start_fill_data | input | 16 | Seed value for a fill |
| wide_mode | input | 1 | Selects the shorter queue latency |
| ext_slot | input | 1 | External access slot |
| src_slot | input | 1 | Host-bus fetch slot |
| after_refresh | input | 1 | This slot directly follows a refresh slot |
| ext_addr | output | 24 | Host-bus read address |
| ext_rdata | input | 16 | Host-bus read data |
| vram_raddr | output | 16 | Copy read address |
| vram_rdata | input | 8 | Copy read data |
| mem_we | output | 1 | Video memory write strobe |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| mem_byte | output | 1 | Write is a single copied byte |
| mem_fill | output | 1 | Write comes from a fill entry |
| run | output | 1 | Transfer in progress |
| cmd | output | 6 | Current command code |
| src_out | output | 24 | Current source pointer |
| len_out | output | 16 | Remaining length |
| dest_out | output | 16 | Current destination |
| q_empty | output | 1 | Write queue is empty |

## Verification
Two pairs of actions can meet in one cycle. In an `ext_slot` the fill re-queue and the queue drain happen together. The bench fills with a continuous `ext_slot` and requires `mem_fill`=1, the seed value and an empty queue after every unit. In a host-bus transfer, a queue push and an older entry's drain can also coincide. The bench issues a `src_slot` in exactly the cycle the first entry comes due. It then expects the write and one remaining entry, and checks that the second entry drains 32 cycles after its own push.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [1:0] {
        MODE_EXT,
        MODE_FILL,
        MODE_COPY
    } dma_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_FILL,
        ST_CP_RD,
        ST_CP_WR
    } dma_state_t;

    function automatic dma_mode_t mode_of(input logic [7:0] hi);
        if (!hi[7])
            return MODE_EXT;
        else if (!hi[6])
            return MODE_FILL;
        else
            return MODE_COPY;
    endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs #(
    parameter int ADDR_W = 16,
    parameter int CMD_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        ld_hi,
    input  logic [7:0]        ld_mid,
    input  logic [7:0]        ld_lo,
    input  logic [15:0]       ld_len,
    input  logic [7:0]        ld_inc,
    input  logic [ADDR_W-1:0] ld_dest,
    input  logic [CMD_W-1:0]  ld_cmd,
    input  logic              adv,
    output logic [7:0]        src_hi,
    output logic [7:0]        src_mid,
    output logic [7:0]        src_lo,
    output logic [15:0]       len,
    output logic [ADDR_W-1:0] dest,
    output logic [CMD_W-1:0]  cmd,
    output logic              last
);
    localparam logic [CMD_W-1:0] CMD_KEEP = CMD_W'(4'hF);

    logic [7:0]  len_hi, len_lo, inc;
    logic [15:0] len_dec;

    assign len     = {len_hi, len_lo};
    assign len_dec = len - 16'd1;
    assign last    = (len_dec == 16'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_hi  <= '0;
            src_mid <= '0;
            src_lo  <= '0;
            len_hi  <= '0;
            len_lo  <= '0;
            inc     <= '0;
            dest    <= '0;
            cmd     <= '0;
        end else if (load) begin
            src_hi  <= ld_hi;
            src_mid <= ld_mid;
            src_lo  <= ld_lo;
            len_hi  <= ld_len[15:8];
            len_lo  <= ld_len[7:0];
            inc     <= ld_inc;
            dest    <= ld_dest;
            cmd     <= ld_cmd;
        end else if (adv) begin
            src_lo <= src_lo + 8'd1;
            if (src_lo == 8'hFF)
                src_mid <= src_mid + 8'd1;
            dest   <= dest + ADDR_W'(inc);
            len_hi <= len_dec[15:8];
            len_lo <= len_dec[7:0];
            if (len_dec == 16'd0)
                cmd <= cmd & CMD_KEEP;
        end
    end

    AST_SRC_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> $stable(src_hi)); // R2
    AST_SRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && src_lo == 8'hFF) |=> src_mid == $past(src_mid) + 8'd1); // R2
    AST_DEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> dest == $past(dest) + ADDR_W'($past(inc))); // R3
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> len == $past(len) - 16'd1); // R4

endmodule

// File: rtl/vdma_queue.sv
module vdma_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CYC_W-1:0]  push_due,
    input  logic              refill,
    input  logic [ADDR_W-1:0] refill_addr,
    input  logic              pop_en,
    output logic              empty,
    output logic              full,
    output logic              drain,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              head_fill
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [CYC_W-1:0]  q_due  [DEPTH];
    logic              q_fill [DEPTH];

    logic [PTR_W-1:0] wr, rd, wr_m1, head_idx, head_nxt;
    logic [CYC_W-1:0] slack;
    logic             head_valid, due_ok;

    assign wr_m1      = wr - 1'b1;
    assign head_idx   = refill ? wr_m1 : rd;
    assign head_nxt   = head_idx + 1'b1;
    assign head_valid = !empty || refill;
    assign slack      = cyc - q_due[rd];
    assign due_ok     = refill || !slack[CYC_W-1];
    assign drain      = pop_en && head_valid && due_ok;
    assign head_addr  = refill ? refill_addr : q_addr[rd];
    assign head_data  = q_data[head_idx];
    assign head_fill  = refill || q_fill[rd];
    assign full       = !empty && (rd == wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr    <= '0;
            rd    <= '0;
            empty <= 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                q_addr[i] <= '0;
                q_data[i] <= '0;
                q_due[i]  <= '0;
                q_fill[i] <= 1'b0;
            end
        end else begin
            if (push) begin
                q_addr[wr] <= push_addr;
                q_data[wr] <= push_data;
                q_due[wr]  <= push_due;
                q_fill[wr] <= 1'b0;
                wr         <= wr + 1'b1;
            end
            if (refill) begin
                q_addr[wr_m1] <= refill_addr;
                q_due[wr_m1]  <= cyc;
                q_fill[wr_m1] <= 1'b1;
            end
            if (drain) begin
                rd    <= head_nxt;
                empty <= (head_nxt == wr) && !push;
            end else if (refill) begin
                rd    <= wr_m1;
                empty <= 1'b0;
            end else if (push) begin
                if (empty)
                    rd <= wr;
                empty <= 1'b0;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_FILL_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && drain) |=> empty); // R6

endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  dma_mode_t start_mode,
    input  logic      ext_slot,
    input  logic      src_slot,
    input  logic      after_refresh,
    input  logic      q_empty,
    input  logic      q_full,
    input  logic      q_drain,
    input  logic      last,
    output logic      run,
    output logic      load,
    output logic      adv,
    output logic      push_ext,
    output logic      push_seed,
    output logic      refill,
    output logic      cp_read,
    output logic      cp_write
);
    dma_state_t state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n   = state;
        load      = 1'b0;
        adv       = 1'b0;
        push_ext  = 1'b0;
        push_seed = 1'b0;
        refill    = 1'b0;
        cp_read   = 1'b0;
        cp_write  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    unique case (start_mode)
                        MODE_EXT:  state_n = ST_EXT;
                        MODE_FILL: begin
                            state_n   = ST_FILL;
                            push_seed = !q_full;
                        end
                        MODE_COPY: state_n = ST_CP_RD;
                        default:   state_n = ST_IDLE;
                    endcase
                end
            end
            ST_EXT: begin
                push_ext = src_slot && !after_refresh && !q_full;
                adv      = push_ext;
                if (adv && last)
                    state_n = ST_IDLE;
            end
            ST_FILL: begin
                refill = ext_slot && q_empty;
                adv    = refill;
                if (adv && last)
                    state_n = ST_IDLE;
            end
            ST_CP_RD: begin
                cp_read = ext_slot && !q_drain;
                if (cp_read)
                    state_n = ST_CP_WR;
            end
            ST_CP_WR: begin
                cp_write = ext_slot && !q_drain;
                adv      = cp_write;
                if (cp_write)
                    state_n = last ? ST_IDLE : ST_CP_RD;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign run = (state != ST_IDLE);

    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> !run); // R4
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_ext, push_seed, refill, cp_read, cp_write})); // R9

endmodule

// File: rtl/vram_dma_seq.sv
module vram_dma_seq
    import vdma_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int CYC_W   = 16,
    parameter int QDEPTH  = 4,
    parameter int LATENCY = 2,
    parameter int CMD_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        start_src_hi,
    input  logic [7:0]        start_src_mid,
    input  logic [7:0]        start_src_lo,
    input  logic [15:0]       start_len,
    input  logic [7:0]        start_inc,
    input  logic [ADDR_W-1:0] start_dest,
    input  logic [CMD_W-1:0]  start_cmd,
    input  logic [DATA_W-1:0] start_fill_data,
    input  logic              wide_mode,
    input  logic              ext_slot,
    input  logic              src_slot,
    input  logic              after_refresh,
    output logic [23:0]       ext_addr,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [15:0]       vram_raddr,
    input  logic [7:0]        vram_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_byte,
    output logic              mem_fill,
    output logic              run,
    output logic [CMD_W-1:0]  cmd,
    output logic [23:0]       src_out,
    output logic [15:0]       len_out,
    output logic [ADDR_W-1:0] dest_out,
    output logic              q_empty
);
    localparam logic [CYC_W-1:0] DLY_WIDE   = CYC_W'(LATENCY * 16);
    localparam logic [CYC_W-1:0] DLY_NARROW = CYC_W'(LATENCY * 20);

    logic [CYC_W-1:0]  cyc, push_due;
    logic [7:0]        src_hi, src_mid, src_lo, cp_latch;
    logic [ADDR_W-1:0] dest, push_addr, q_head_addr;
    logic [DATA_W-1:0] push_data, q_head_data;
    logic load, adv, last, push_ext, push_seed, refill, cp_read, cp_write;
    logic q_full, q_drain, q_head_fill, latch_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= '0;
        else
            cyc <= cyc + 1'b1;
    end

    vdma_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_mode(mode_of(start_src_hi)),
        .ext_slot(ext_slot), .src_slot(src_slot), .after_refresh(after_refresh),
        .q_empty(q_empty), .q_full(q_full), .q_drain(q_drain), .last(last),
        .run(run), .load(load), .adv(adv), .push_ext(push_ext),
        .push_seed(push_seed), .refill(refill), .cp_read(cp_read), .cp_write(cp_write)
    );

    vdma_regs #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_hi(start_src_hi), .ld_mid(start_src_mid), .ld_lo(start_src_lo),
        .ld_len(start_len), .ld_inc(start_inc), .ld_dest(start_dest), .ld_cmd(start_cmd),
        .adv(adv), .src_hi(src_hi), .src_mid(src_mid), .src_lo(src_lo),
        .len(len_out), .dest(dest), .cmd(cmd), .last(last)
    );

    assign push_addr = push_seed ? start_dest : dest;
    assign push_data = push_seed ? start_fill_data : ext_rdata;
    assign push_due  = push_seed ? cyc : cyc + (wide_mode ? DLY_WIDE : DLY_NARROW);

    vdma_queue #(.DEPTH(QDEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .cyc(cyc),
        .push(push_ext || push_seed), .push_addr(push_addr), .push_data(push_data),
        .push_due(push_due), .refill(refill), .refill_addr(dest), .pop_en(ext_slot),
        .empty(q_empty), .full(q_full), .drain(q_drain),
        .head_addr(q_head_addr), .head_data(q_head_data), .head_fill(q_head_fill)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_latch  <= '0;
            latch_vld <= 1'b0;
        end else if (cp_read) begin
            cp_latch  <= vram_rdata;
            latch_vld <= 1'b1;
        end else if (cp_write) begin
            latch_vld <= 1'b0;
        end
    end

    assign ext_addr   = {src_hi, src_mid, src_lo};
    assign src_out    = ext_addr;
    assign dest_out   = dest;
    assign vram_raddr = {src_mid, src_lo} ^ 16'h0001;
    assign mem_we     = q_drain || cp_write;
    assign mem_addr   = q_drain ? q_head_addr : (dest ^ ADDR_W'(1));
    assign mem_wdata  = q_drain ? q_head_data : DATA_W'(cp_latch);
    assign mem_byte   = !q_drain && cp_write;
    assign mem_fill   = q_drain && q_head_fill;

    AST_COPY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cp_write |-> latch_vld); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_read |=> latch_vld); // R5

endmodule

// File: tb/vram_dma_seq_tb_top.sv
module vram_dma_seq_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  s_hi = '0, s_mid = '0, s_lo = '0, s_inc = '0;
    logic [15:0] s_len = '0, s_dest = '0, s_fill = '0;
    logic [5:0]  s_cmd = '0;
    logic        wide_mode = 1'b1, ext_slot = 1'b0, src_slot = 1'b0, after_refresh = 1'b0;
    logic [15:0] ext_rdata = '0;
    logic [7:0]  vram_rdata = '0;
    logic [23:0] ext_addr, src_out;
    logic [15:0] vram_raddr, mem_addr, mem_wdata, len_out, dest_out;
    logic        mem_we, mem_byte, mem_fill, run, q_empty;
    logic [5:0]  cmd;

    int checks = 0, errors = 0, bcyc = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    vram_dma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_src_hi(s_hi), .start_src_mid(s_mid), .start_src_lo(s_lo),
        .start_len(s_len), .start_inc(s_inc), .start_dest(s_dest), .start_cmd(s_cmd),
        .start_fill_data(s_fill), .wide_mode(wide_mode), .ext_slot(ext_slot),
        .src_slot(src_slot), .after_refresh(after_refresh), .ext_addr(ext_addr),
        .ext_rdata(ext_rdata), .vram_raddr(vram_raddr), .vram_rdata(vram_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_byte(mem_byte),
        .mem_fill(mem_fill), .run(run), .cmd(cmd), .src_out(src_out), .len_out(len_out),
        .dest_out(dest_out), .q_empty(q_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        bcyc++;
    endtask

    task automatic do_start(input logic [7:0] hi, mid, lo, input logic [15:0] len,
                            input logic [7:0] inc, input logic [15:0] dest,
                            input logic [5:0] c, input logic [15:0] fill);
        s_hi = hi; s_mid = mid; s_lo = lo; s_len = len; s_inc = inc;
        s_dest = dest; s_cmd = c; s_fill = fill; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic wait_we(output int at);
        int guard = 0;
        #1;
        while (mem_we !== 1'b1 && guard < 200) begin
            step();
            guard++;
        end
        at = bcyc;
    endtask

    task automatic t_reset();
        chk("R1 reset run", run, 0);
        chk("R1 reset q_empty", q_empty, 1);
        chk("R1 reset len", len_out, 0);
        chk("R1 reset src", src_out, 0);
        chk("R1 reset mem_we", mem_we, 0);
    endtask

    task automatic t_copy();
        do_start(8'hC0, 8'h12, 8'hFF, 16'd2, 8'd2, 16'h0100, 6'h31, 16'h0);
        chk("R1 copy run", run, 1);
        ext_slot = 1'b1; vram_rdata = 8'hA5;
        #1;
        chk("R5 copy read addr", vram_raddr, 16'h12FE);
        chk("R5 no write on read", mem_we, 0);
        step();
        vram_rdata = 8'h3C;
        #1;
        chk("R5 copy we", mem_we, 1);
        chk("R5 copy addr", mem_addr, 16'h0101);
        chk("R5 copy data", mem_wdata, 16'h00A5);
        chk("R5 copy byte", mem_byte, 1);
        step();
        chk("R2 carry into mid", src_out, 24'hC01300);
        chk("R3 dest step", dest_out, 16'h0102);
        chk("R4 len dec", len_out, 1);
        #1;
        chk("R5 second read addr", vram_raddr, 16'h1301);
        step();
        #1;
        chk("R5 second write addr", mem_addr, 16'h0103);
        chk("R5 second write data", mem_wdata, 16'h003C);
        step();
        ext_slot = 1'b0;
        chk("R4 copy ends", run, 0);
        chk("R4 len zero", len_out, 0);
        chk("R4 cmd masked", cmd, 6'h01);
        chk("R2 hi held", src_out, 24'hC01301);
    endtask

    task automatic t_ext_overlap();
        int t0, t1, t2, at;
        wide_mode = 1'b1;
        ext_slot = 1'b1;
        do_start(8'h00, 8'h20, 8'h10, 16'd3, 8'd1, 16'h4000, 6'h21, 16'h0);
        src_slot = 1'b1; after_refresh = 1'b1;
        step();
        chk("R8 refresh blocks push", q_empty, 1);
        chk("R8 refresh keeps len", len_out, 3);
        after_refresh = 1'b0; ext_rdata = 16'hBEEF;
        #1;
        chk("R7 ext addr", ext_addr, 24'h002010);
        step();
        t0 = bcyc;
        src_slot = 1'b0;
        chk("R7 pushed", q_empty, 0);
        chk("R2 lo inc", src_out, 24'h002011);
        chk("R3 dest inc", dest_out, 16'h4001);
        wait_we(at);
        chk("R7 wide latency", at - t0, 31);
        chk("R9 drain addr", mem_addr, 16'h4000);
        chk("R9 drain data", mem_wdata, 16'hBEEF);
        src_slot = 1'b1; ext_rdata = 16'h1234;
        t1 = bcyc;
        step();
        chk("R9 push with drain keeps one", q_empty, 0);
        chk("R4 len after overlap", len_out, 1);
        wide_mode = 1'b0; ext_rdata = 16'h5678;
        t2 = bcyc;
        step();
        src_slot = 1'b0;
        chk("R4 ext ends", run, 0);
        chk("R4 cmd masked ext", cmd, 6'h01);
        wait_we(at);
        chk("R9 second latency", at - t1, 32);
        chk("R9 second addr", mem_addr, 16'h4001);
        chk("R9 second data", mem_wdata, 16'h1234);
        step();
        wait_we(at);
        chk("R7 narrow latency", at - t2, 40);
        chk("R9 third addr", mem_addr, 16'h4002);
        step();
        chk("R9 queue drained", q_empty, 1);
        ext_slot = 1'b0;
        wide_mode = 1'b1;
    endtask

    task automatic t_full();
        int drains = 0, guard = 0;
        do_start(8'h40, 8'h00, 8'h00, 16'd6, 8'd2, 16'h0000, 6'h21, 16'h0);
        src_slot = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk("R8 full blocks push", len_out, 2);
        ext_slot = 1'b1;
        while ((run || !q_empty) && guard < 500) begin
            #1;
            if (mem_we) drains++;
            step();
            guard++;
        end
        src_slot = 1'b0; ext_slot = 1'b0;
        chk("R9 all entries drained", drains, 6);
        chk("R3 dest after six", dest_out, 16'h000C);
    endtask

    task automatic t_fill();
        do_start(8'h80, 8'h00, 8'h00, 16'd2, 8'd4, 16'h8000, 6'h23, 16'h7E7E);
        chk("R6 seed queued", q_empty, 0);
        chk("R6 seed no advance", len_out, 2);
        ext_slot = 1'b1;
        #1;
        chk("R6 seed drain addr", mem_addr, 16'h8000);
        chk("R6 seed not fill", mem_fill, 0);
        step();
        chk("R6 empty after seed", q_empty, 1);
        #1;
        chk("R6 fill we", mem_we, 1);
        chk("R6 fill flag", mem_fill, 1);
        chk("R6 fill data", mem_wdata, 16'h7E7E);
        chk("R6 fill addr", mem_addr, 16'h8000);
        step();
        chk("R6 empty after fill", q_empty, 1);
        chk("R3 fill dest", dest_out, 16'h8004);
        chk("R4 fill len", len_out, 1);
        #1;
        chk("R6 second fill addr", mem_addr, 16'h8004);
        step();
        ext_slot = 1'b0;
        chk("R4 fill ends", run, 0);
        chk("R4 fill cmd", cmd, 6'h03);
    endtask

    task automatic t_len_one();
        do_start(8'h00, 8'h00, 8'h50, 16'd1, 8'd2, 16'h2000, 6'h3F, 16'h0);
        src_slot = 1'b1;
        step();
        chk("R4 single unit ends", run, 0);
        chk("R4 single cmd", cmd, 6'h0F);
        step();
        src_slot = 1'b0;
        chk("R4 no second unit", dest_out, 16'h2002);
        chk("R1 start ignored check len", len_out, 0);
        ext_slot = 1'b1;
        for (int i = 0; i < 45; i++) step();
        ext_slot = 1'b0;
        chk("R9 single drained", q_empty, 1);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 2 + 1);
        t_reset();
        rst_n = 1'b1;
        step();
        t_copy();
        t_ext_overlap();
        t_full();
        t_fill();
        t_len_one();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule